// File: doc/BRIEF.md
# Multi-Channel PWM Timer Bank

This block holds eight independent 16-bit up-counting timers behind a small memory-mapped register bus. Each timer picks one of three count sources: the peripheral clock, the real-time clock or an external input. Every source is sampled in the bus clock domain, and its rising edges are divided down by a power-of-four prescaler before they advance the counter. Each timer compares its counter against two values it holds, a full value and a half value. A match raises a separate full or half flag, and the full match also makes the counter wrap.

A timer can drive a PWM pin. The pin is active from count 0 until the half value, and a control bit inverts it. When software turns the PWM off, the pin either drops to its inactive level at once or finishes the current period first. Four global registers control every channel at once: enable, stop, flag and mask. Each has a plain address plus a set alias and a clear alias, so software never has to read, modify and write them. A single interrupt line is raised while any unmasked flag is set.

All accesses are 32-bit wide and must be word-aligned. The channel registers hold 16 bits, ignore the upper half of write data and read back with zeros in the upper half.

Top module: `mtmr_bank`

## Requirements
- R1: After reset the enable, stop and flag registers read 0, the mask register reads 0xFFFFFFFF, `irq_o` is 0 and every `pwm_o` bit is 0.
- R2: Each global register is reached through three offsets: enable at 0x00/0x04/0x08, flag at 0x10/0x14/0x18, mask at 0x20/0x24/0x28 and stop at 0x0C/0x1C/0x2C. The first offset of each triple loads the whole value. The second ORs the written 1 bits into the register and the third clears them; 0 bits leave the register unchanged.
- R3: Channel n owns four 16-bit registers starting at 0x30 + 0x10·n: full value at +0x0, half value at +0x4, counter at +0x8 and control at +0xC. Each reads back what was last written, with bits [31:16] ignored on write and read as 0. A write to one channel does not change another channel's counter.
- R4: A channel counts only while its enable bit (bit n) is 1 and its stop bit (bit n) is 0; otherwise its counter holds.
- R5: Control bits [2:0] select the count source: bit 0 selects `src_pclk`, bit 1 `src_rtc` and bit 2 `src_ext`. Only rising edges of a selected source advance the prescaler; edges on unselected sources are ignored.
- R6: Control bits [5:3] give the prescale code. Codes 0 to 5 need 1, 4, 16, 64, 256 or 1024 source edges per counter step, and codes 6 and 7 behave as code 5. A control write restarts the prescaler.
- R7: On a step from a count equal to the full value the counter goes to 0. A step that makes the counter equal to the full value sets flag bit n.
- R8: A step that makes the counter equal to the half value sets flag bit n+16.
- R9: `irq_o` is 1 exactly when some flag bit is 1 and the matching mask bit is 0.
- R10: With control bit 7 set, `pwm_o[n]` is 1 while the counter is below the half value and 0 otherwise. Control bit 8 inverts it, making 1 the inactive level.
- R11: Clearing bit 7 while bit 9 is 1 drives `pwm_o[n]` to the inactive level (the value of bit 8) in the next cycle.
- R12: Clearing bit 7 while bit 9 is 0 keeps the waveform going until the counter wraps from the full value to 0, after which `pwm_o[n]` stays at the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 8 | Word-aligned byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_pclk | input | 1 | Peripheral clock count source, sampled as a level |
| src_rtc | input | 1 | Real-time clock count source, sampled as a level |
| src_ext | input | 1 | External count source, sampled as a level |
| pwm_o | output | 8 | One PWM pin per channel |
| irq_o | output | 1 | Interrupt request |

## Verification
The graceful PWM shutdown is the hardest behaviour to reach from the ports. It needs a pin that is still live after its enable bit has gone, and the bench has to tell that apart from a pin that shut down at once. The stimulus puts a channel in a short period with a small half value and writes the shutdown with the counter at 0. It then steps the source edge by edge, checking the pin before the half point, after it and again after the wrap. The 1024 prescale boundary is reached by issuing exactly 1023 and then one more source pulse.

// File: rtl/mtmr_pkg.sv
`timescale 1ns/1ps
// Shared constants, control-word layout and the set/clear alias helper
// for the timer bank. Assumes a 32-bit bus and 16-bit channel registers.
package mtmr_pkg;
    localparam int BUS_W     = 32;
    localparam int CTRL_W    = 16;
    localparam int CH_BASE   = 'h30;
    localparam int CH_STRIDE = 'h10;
    localparam int HALF_OFS  = 16;   // half flags sit 16 bits above full flags
    localparam int MAX_CODE  = 5;    // largest prescale code (divide by 1024)

    typedef enum logic [1:0] {OP_LOAD, OP_SET, OP_CLR, OP_NONE} gop_e;

    typedef struct packed {
        logic [5:0] rsvd_hi;
        logic       abrupt;   // bit 9
        logic       act_low;  // bit 8
        logic       pwm_en;   // bit 7
        logic       rsvd6;
        logic [2:0] pre;      // bits 5:3
        logic [2:0] src;      // bits 2:0
    } ctrl_t;

    // Apply a load/set/clear operation to a global register value.
    function automatic logic [BUS_W-1:0] apply_op(logic [BUS_W-1:0] cur,
                                                  logic [BUS_W-1:0] d,
                                                  gop_e op);
        case (op)
            OP_LOAD: return d;
            OP_SET:  return cur | d;
            OP_CLR:  return cur & ~d;
            default: return cur;
        endcase
    endfunction
endpackage

// File: rtl/mtmr_tick.sv
`timescale 1ns/1ps
// Count-tick generator for one channel: picks the selected source edges
// and divides them by 4**code. Assumes src_edge is already one cycle wide.
module mtmr_tick #(
    parameter int MAXC = mtmr_pkg::MAX_CODE
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [2:0] src_edge,
    input  logic [2:0] src_sel,
    input  logic [2:0] pre_code,
    output logic       tick
);
    localparam int PW = 2 * MAXC;

    logic          sel_edge;
    logic [2:0]    code_c;
    logic [PW-1:0] lim;
    logic [PW-1:0] pre_q;

    // Merge selected edges and derive the divider limit.
    always_comb begin
        sel_edge = |(src_edge & src_sel);
        code_c   = (int'(pre_code) > MAXC) ? 3'(MAXC) : pre_code;
        lim      = PW'((1 << (2 * int'(code_c))) - 1);
        tick     = run && sel_edge && (pre_q == lim);
    end

    // Prescale counter, held at zero while the channel is idle.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run)
            pre_q <= '0;
        else if (sel_edge)
            pre_q <= (pre_q == lim) ? '0 : pre_q + PW'(1);
    end
endmodule

// File: rtl/mtmr_pwm.sv
`timescale 1ns/1ps
// PWM pin driver with polarity and abrupt or graceful shutdown.
// Assumes wrap_tick marks the step from the full value back to zero.
module mtmr_pwm (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic act_low,
    input  logic abrupt,
    input  logic active,
    input  logic wrap_tick,
    output logic pwm_o
);
    logic run_q;
    logic live;

    // Remember that the pin is live until the shutdown rule ends it.
    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= 1'b0;
        else if (en)         run_q <= 1'b1;
        else if (abrupt)     run_q <= 1'b0;
        else if (wrap_tick)  run_q <= 1'b0;
    end

    // Drive the waveform while live, the inactive level otherwise.
    always_comb begin
        live  = en || (run_q && !abrupt);
        pwm_o = live ? (active ^ act_low) : act_low;
    end
endmodule

// File: rtl/mtmr_chan.sv
`timescale 1ns/1ps
// One timer channel: full/half/control registers, the up-counter with
// compare events, and its tick and PWM helpers. Assumes CW <= 16.
module mtmr_chan
    import mtmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [2:0]        src_edge,
    input  logic              wr_full,
    input  logic              wr_half,
    input  logic              wr_cnt,
    input  logic              wr_ctrl,
    input  logic [CTRL_W-1:0] wd,
    output logic [CW-1:0]     full_o,
    output logic [CW-1:0]     half_o,
    output logic [CW-1:0]     cnt_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              half_hit,
    output logic              full_hit,
    output logic              pwm_o
);
    ctrl_t         ctrl_q;
    logic [CW-1:0] full_q, half_q, cnt_q, cnt_nx;
    logic          tick, wrap, step;

    mtmr_tick u_tick (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(wr_ctrl),
        .src_edge(src_edge), .src_sel(ctrl_q.src), .pre_code(ctrl_q.pre),
        .tick(tick)
    );

    // Next count and compare events for a counting step.
    always_comb begin
        wrap     = (cnt_q == full_q);
        cnt_nx   = wrap ? '0 : cnt_q + CW'(1);
        step     = tick && !wr_cnt;
        half_hit = step && (cnt_nx == half_q);
        full_hit = step && (cnt_nx == full_q);
    end

    // Software-visible registers and the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= '0;
            half_q <= '0;
            cnt_q  <= '0;
            ctrl_q <= '0;
        end else begin
            if (wr_full) full_q <= wd[CW-1:0];
            if (wr_half) half_q <= wd[CW-1:0];
            if (wr_ctrl) ctrl_q <= ctrl_t'(wd);
            if (wr_cnt)  cnt_q  <= wd[CW-1:0];
            else if (tick) cnt_q <= cnt_nx;
        end
    end

    mtmr_pwm u_pwm (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q.pwm_en), .act_low(ctrl_q.act_low),
        .abrupt(ctrl_q.abrupt), .active(cnt_q < half_q),
        .wrap_tick(step && wrap), .pwm_o(pwm_o)
    );

    assign full_o = full_q;
    assign half_o = half_q;
    assign cnt_o  = cnt_q;
    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/mtmr_bank.sv
`timescale 1ns/1ps
// Timer bank top: address decode, the global enable/stop/flag/mask
// registers with set/clear aliases, source edge detection, the read
// mux and the interrupt. Assumes word-aligned accesses; NCH <= 16.
module mtmr_bank
    import mtmr_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 16,
    parameter int AW  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             src_pclk,
    input  logic             src_rtc,
    input  logic             src_ext,
    output logic [NCH-1:0]   pwm_o,
    output logic             irq_o
);
    localparam int IW = AW - 4;

    logic [NCH-1:0]   en_q, stop_q;
    logic [BUS_W-1:0] flag_q, mask_q, hw_set;
    logic [BUS_W-1:0] en_nx, stop_nx, flag_nx, mask_nx;
    logic [2:0]       src_q, src_now, src_edge;
    gop_e             en_op, stop_op, flag_op, mask_op;
    logic             in_ch;
    logic [AW-1:0]    rel;
    logic [IW-1:0]    ch_idx;
    logic [NCH-1:0]   wr_full, wr_half, wr_cnt, wr_ctrl, half_hit, full_hit;
    logic [CW-1:0]    full_v [NCH];
    logic [CW-1:0]    half_v [NCH];
    logic [CW-1:0]    cnt_v  [NCH];
    logic [CTRL_W-1:0] ctrl_v [NCH];

    // Decode which global register and alias the address selects.
    always_comb begin
        en_op = OP_NONE; stop_op = OP_NONE; flag_op = OP_NONE; mask_op = OP_NONE;
        if (bus_we) begin
            case (bus_addr)
                AW'('h00): en_op   = OP_LOAD;
                AW'('h04): en_op   = OP_SET;
                AW'('h08): en_op   = OP_CLR;
                AW'('h0C): stop_op = OP_LOAD;
                AW'('h1C): stop_op = OP_SET;
                AW'('h2C): stop_op = OP_CLR;
                AW'('h10): flag_op = OP_LOAD;
                AW'('h14): flag_op = OP_SET;
                AW'('h18): flag_op = OP_CLR;
                AW'('h20): mask_op = OP_LOAD;
                AW'('h24): mask_op = OP_SET;
                AW'('h28): mask_op = OP_CLR;
                default: ;
            endcase
        end
        rel    = bus_addr - AW'(CH_BASE);
        ch_idx = rel[AW-1:4];
        in_ch  = (bus_addr >= AW'(CH_BASE)) &&
                 (bus_addr < AW'(CH_BASE + NCH * CH_STRIDE));
    end

    // Collect hardware compare events into flag bit positions.
    always_comb begin
        hw_set = '0;
        for (int n = 0; n < NCH; n++) begin
            hw_set[n]            = full_hit[n];
            hw_set[HALF_OFS + n] = half_hit[n];
        end
        en_nx   = apply_op(BUS_W'(en_q), bus_wdata, en_op);
        stop_nx = apply_op(BUS_W'(stop_q), bus_wdata, stop_op);
        flag_nx = apply_op(flag_q, bus_wdata, flag_op) | hw_set;
        mask_nx = apply_op(mask_q, bus_wdata, mask_op);
        src_now  = {src_ext, src_rtc, src_pclk};
        src_edge = src_now & ~src_q;
    end

    // Global registers and the source sampling stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            stop_q <= '0;
            flag_q <= '0;
            mask_q <= '1;
            src_q  <= '0;
        end else begin
            en_q   <= en_nx[NCH-1:0];
            stop_q <= stop_nx[NCH-1:0];
            flag_q <= flag_nx;
            mask_q <= mask_nx;
            src_q  <= src_now;
        end
    end

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic sel;
        assign sel        = bus_we && in_ch && (ch_idx == IW'(n));
        assign wr_full[n] = sel && (bus_addr[3:2] == 2'd0);
        assign wr_half[n] = sel && (bus_addr[3:2] == 2'd1);
        assign wr_cnt[n]  = sel && (bus_addr[3:2] == 2'd2);
        assign wr_ctrl[n] = sel && (bus_addr[3:2] == 2'd3);

        mtmr_chan #(.CW(CW)) u_chan (
            .clk(clk), .rst_n(rst_n), .run(en_q[n] && !stop_q[n]),
            .src_edge(src_edge), .wr_full(wr_full[n]), .wr_half(wr_half[n]),
            .wr_cnt(wr_cnt[n]), .wr_ctrl(wr_ctrl[n]), .wd(bus_wdata[CTRL_W-1:0]),
            .full_o(full_v[n]), .half_o(half_v[n]), .cnt_o(cnt_v[n]),
            .ctrl_o(ctrl_v[n]), .half_hit(half_hit[n]), .full_hit(full_hit[n]),
            .pwm_o(pwm_o[n])
        );
    end

    // Read mux over global and channel registers.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            AW'('h00), AW'('h04), AW'('h08): bus_rdata = BUS_W'(en_q);
            AW'('h0C), AW'('h1C), AW'('h2C): bus_rdata = BUS_W'(stop_q);
            AW'('h10), AW'('h14), AW'('h18): bus_rdata = flag_q;
            AW'('h20), AW'('h24), AW'('h28): bus_rdata = mask_q;
            default: begin
                for (int n = 0; n < NCH; n++) begin
                    if (in_ch && ch_idx == IW'(n)) begin
                        case (bus_addr[3:2])
                            2'd0:    bus_rdata = BUS_W'(full_v[n]);
                            2'd1:    bus_rdata = BUS_W'(half_v[n]);
                            2'd2:    bus_rdata = BUS_W'(cnt_v[n]);
                            default: bus_rdata = BUS_W'(ctrl_v[n]);
                        endcase
                    end
                end
            end
        endcase
    end

    assign irq_o = |(flag_q & ~mask_q);
endmodule

// File: rtl/mtmr_chk.sv
`timescale 1ns/1ps
// Property checker for the timer bank, attached to every instance by bind.
// Observes ports plus the counter, compare and control state per channel.
module mtmr_chk #(
    parameter int NCH = 8,
    parameter int CW  = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           irq_o,
    input logic [NCH-1:0] pwm_o,
    input logic [NCH-1:0] en_q,
    input logic [NCH-1:0] stop_q,
    input logic [31:0]    flag_q,
    input logic [31:0]    mask_q,
    input logic [NCH-1:0] wr_cnt,
    input logic [CW-1:0]  cnt_v  [NCH],
    input logic [CW-1:0]  full_v [NCH],
    input logic [15:0]    ctrl_v [NCH]
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_q == '1 && flag_q == '0 && en_q == '0 && stop_q == '0));

    a_r9_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !irq_o);

    for (genvar n = 0; n < NCH; n++) begin : g_p
        a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
            (!(en_q[n] && !stop_q[n]) && !wr_cnt[n]) |=> $stable(cnt_v[n]));

        a_r7_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_v[n] == full_v[n] && !wr_cnt[n]) |=> (cnt_v[n] == '0 || $stable(cnt_v[n])));

        a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_cnt[n] |=> (cnt_v[n] == '0 || $stable(cnt_v[n]) ||
                            cnt_v[n] == $past(cnt_v[n]) + CW'(1)));

        a_r11_abrupt_idle: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl_v[n][7] && ctrl_v[n][9]) |-> (pwm_o[n] == ctrl_v[n][8]));
    end
endmodule

bind mtmr_bank mtmr_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .pwm_o(pwm_o), .en_q(en_q),
    .stop_q(stop_q), .flag_q(flag_q), .mask_q(mask_q), .wr_cnt(wr_cnt),
    .cnt_v(cnt_v), .full_v(full_v), .ctrl_v(ctrl_v)
);

// File: tb/sim_mtmr_bank.sv
`timescale 1ns/1ps
// Bench for the timer bank: a register-access vector table, then directed
// tests for counting, sources, prescale, flags, interrupt and PWM.
module sim_mtmr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  srcs = '0;
    logic [7:0]  pwm_o;
    logic        irq_o;
    int          errors = 0;
    int          checks = 0;

    always #2.5 clk = ~clk;

    mtmr_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_pclk(srcs[0]),
        .src_rtc(srcs[1]), .src_ext(srcs[2]), .pwm_o(pwm_o), .irq_o(irq_o)
    );

    // {write, addr, data, expected read}
    localparam int NV = 36;
    localparam logic [72:0] VEC [NV] = '{
        {1'b1, 8'h04, 32'h0000_0005, 32'h0}, {1'b0, 8'h00, 32'h0, 32'h0000_0005},
        {1'b1, 8'h08, 32'h0000_0001, 32'h0}, {1'b0, 8'h00, 32'h0, 32'h0000_0004},
        {1'b1, 8'h1C, 32'h0000_0003, 32'h0}, {1'b0, 8'h0C, 32'h0, 32'h0000_0003},
        {1'b1, 8'h2C, 32'h0000_0002, 32'h0}, {1'b0, 8'h0C, 32'h0, 32'h0000_0001},
        {1'b1, 8'h0C, 32'h0000_0000, 32'h0}, {1'b0, 8'h0C, 32'h0, 32'h0000_0000},
        {1'b1, 8'h28, 32'h0001_0001, 32'h0}, {1'b0, 8'h20, 32'h0, 32'hFFFE_FFFE},
        {1'b1, 8'h24, 32'h0000_0001, 32'h0}, {1'b0, 8'h20, 32'h0, 32'hFFFE_FFFF},
        {1'b1, 8'h24, 32'h0001_0000, 32'h0}, {1'b0, 8'h20, 32'h0, 32'hFFFF_FFFF},
        {1'b1, 8'h14, 32'h0002_0002, 32'h0}, {1'b0, 8'h10, 32'h0, 32'h0002_0002},
        {1'b1, 8'h18, 32'h0000_0002, 32'h0}, {1'b0, 8'h10, 32'h0, 32'h0002_0000},
        {1'b1, 8'h18, 32'h0002_0000, 32'h0}, {1'b0, 8'h10, 32'h0, 32'h0000_0000},
        {1'b1, 8'h50, 32'h1234_5678, 32'h0}, {1'b0, 8'h50, 32'h0, 32'h0000_5678},
        {1'b1, 8'h54, 32'h0000_ABCD, 32'h0}, {1'b0, 8'h54, 32'h0, 32'h0000_ABCD},
        {1'b1, 8'h58, 32'h0000_00FF, 32'h0}, {1'b0, 8'h58, 32'h0, 32'h0000_00FF},
        {1'b1, 8'h5C, 32'h0000_03FF, 32'h0}, {1'b0, 8'h5C, 32'h0, 32'h0000_03FF},
        {1'b1, 8'hA8, 32'h0000_1111, 32'h0}, {1'b0, 8'hA8, 32'h0, 32'h0000_1111},
        {1'b0, 8'h98, 32'h0, 32'h0000_0000}, {1'b1, 8'h08, 32'h0000_0004, 32'h0},
        {1'b0, 8'h00, 32'h0, 32'h0000_0000}, {1'b0, 8'h58, 32'h0, 32'h0000_00FF}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic pulse(input int s, input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); srcs[s] = 1'b1;
            @(negedge clk); srcs[s] = 1'b0;
        end
    endtask

    task automatic pin(input string req, input int ch, input logic exp);
        @(negedge clk);
        #1 chk(req, {31'b0, pwm_o[ch]}, {31'b0, exp});
    endtask

    initial begin : watchdog
        #500000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(8'h00, v); chk("R1 enable", v, 32'h0);
        rd(8'h0C, v); chk("R1 stop", v, 32'h0);
        rd(8'h10, v); chk("R1 flag", v, 32'h0);
        rd(8'h20, v); chk("R1 mask", v, 32'hFFFF_FFFF);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
        chk("R1 pwm", {24'b0, pwm_o}, 32'h0);

        // R2/R3 register access table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
            else begin
                rd(VEC[i][71:64], v);
                chk(VEC[i][71:64] < 8'h30 ? "R2 alias" : "R3 channel", v, VEC[i][31:0]);
            end
        end

        // R4 gating on channel 0
        wr(8'h30, 32'hFFFF); wr(8'h34, 32'hFFFF); wr(8'h3C, 32'h0001); wr(8'h38, 32'h0);
        pulse(0, 3); rd(8'h38, v); chk("R4 disabled holds", v, 32'd0);
        wr(8'h04, 32'h1); pulse(0, 3); rd(8'h38, v); chk("R4 counts", v, 32'd3);
        wr(8'h1C, 32'h1); pulse(0, 2); rd(8'h38, v); chk("R4 stopped holds", v, 32'd3);
        wr(8'h2C, 32'h1);
        // R5 source selection
        pulse(1, 2); rd(8'h38, v); chk("R5 rtc ignored", v, 32'd3);
        wr(8'h3C, 32'h0002); pulse(1, 2); rd(8'h38, v); chk("R5 rtc counts", v, 32'd5);
        pulse(0, 1); rd(8'h38, v); chk("R5 pclk ignored", v, 32'd5);
        wr(8'h3C, 32'h0004); pulse(2, 1); rd(8'h38, v); chk("R5 ext counts", v, 32'd6);
        // R6 prescale
        wr(8'h3C, 32'h0009); wr(8'h38, 32'h0);
        pulse(0, 3); rd(8'h38, v); chk("R6 div4 before", v, 32'd0);
        pulse(0, 1); rd(8'h38, v); chk("R6 div4 step", v, 32'd1);
        wr(8'h3C, 32'h0029); wr(8'h38, 32'h0);
        pulse(0, 1023); rd(8'h38, v); chk("R6 div1024 before", v, 32'd0);
        pulse(0, 1); rd(8'h38, v); chk("R6 div1024 step", v, 32'd1);

        // R7/R8 compare flags on channel 1
        wr(8'h40, 32'd5); wr(8'h44, 32'd2); wr(8'h4C, 32'h0001); wr(8'h48, 32'h0);
        wr(8'h04, 32'h2);
        pulse(0, 2); rd(8'h10, v); chk("R8 half flag", v, 32'h0002_0000);
        pulse(0, 3); rd(8'h10, v); chk("R7 full flag", v, 32'h0002_0002);
        pulse(0, 1); rd(8'h48, v); chk("R7 wrap to zero", v, 32'd0);
        // R9 interrupt masking
        chk("R9 masked", {31'b0, irq_o}, 32'h0);
        wr(8'h28, 32'h2); #1 chk("R9 unmasked", {31'b0, irq_o}, 32'h1);
        wr(8'h24, 32'h2); #1 chk("R9 remasked", {31'b0, irq_o}, 32'h0);
        wr(8'h28, 32'h0002_0000); #1 chk("R9 half unmasked", {31'b0, irq_o}, 32'h1);
        wr(8'h18, 32'h0002_0000); #1 chk("R9 flag cleared", {31'b0, irq_o}, 32'h0);
        wr(8'h24, 32'hFFFF_FFFF); wr(8'h18, 32'hFFFF_FFFF);

        // R10 waveform and polarity
        wr(8'h48, 32'h0); wr(8'h4C, 32'h0081);
        pin("R10 active below half", 1, 1'b1);
        pulse(0, 2); pin("R10 inactive at half", 1, 1'b0);
        pulse(0, 4); pin("R10 active after wrap", 1, 1'b1);
        wr(8'h4C, 32'h0181); pin("R10 inverted", 1, 1'b0);
        pulse(0, 2); pin("R10 inverted idle", 1, 1'b1);
        // R11 abrupt shutdown
        wr(8'h4C, 32'h0381); wr(8'h48, 32'h0); pin("R11 live before", 1, 1'b0);
        wr(8'h4C, 32'h0301); pin("R11 forced inactive", 1, 1'b1);
        // R12 graceful shutdown
        wr(8'h4C, 32'h0081); wr(8'h48, 32'h0); pin("R12 live", 1, 1'b1);
        wr(8'h4C, 32'h0001); pin("R12 held after disable", 1, 1'b1);
        pulse(0, 1); pin("R12 still active", 1, 1'b1);
        pulse(0, 1); pin("R12 waveform low phase", 1, 1'b0);
        pulse(0, 4); rd(8'h48, v); chk("R12 wrapped", v, 32'd0);
        pin("R12 inactive after wrap", 1, 1'b0);
        pulse(0, 1); pin("R12 stays inactive", 1, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule